// File: doc/BRIEF.md
# Supervisory Reset Pulse Generator

This block produces the reset for a processor from three causes: a synchronous supply-good flag that drops while the supply is under its threshold, an active-low manual reset request, and a single-cycle expiry pulse from a watchdog. Any cause asserts reset at the next clock edge. Reset then stays asserted for a fixed number of clock cycles, the stretch period, counted from the last clock edge that saw a cause active. A new cause during the stretch starts the whole period again.

Short low glitches on the manual input are filtered out. A low level counts as a request only after it has been sampled on a set number of consecutive edges. Otherwise the input is treated as high, the way a pulled-up pin with nothing driving it reads. Reset comes out as two separately registered outputs, one active low and one active high. The active-high state is also exported so that an external watchdog can hold itself cleared while reset is active.

Top module: `rst_supervisor`

## Requirements
- R1: A low level on `supply_ok_i` sampled at a clock edge makes `rst_o` high, and `rst_n_o` low, after the next clock edge.
- R2: After `supply_ok_i` returns high, reset deasserts at exactly the TRP_CYC-th clock edge after the last edge that sampled it low.
- R3: A manual low held for at least GLITCH_CYC consecutive sampled edges asserts reset. Reset then deasserts at exactly the TRP_CYC-th edge after the first edge that samples `mr_n_i` high again.
- R4: A manual low seen on fewer than GLITCH_CYC consecutive edges is ignored, and reset stays low throughout.
- R5: A one-cycle high pulse on `wdt_expire_i` produces a reset lasting exactly TRP_CYC clock cycles.
- R6: `rst_n_o` is the exact complement of `rst_o` in every cycle, including while `arst_n` is low.
- R7: While `arst_n` is low, reset is asserted. With no cause active, reset deasserts at the TRP_CYC-th clock edge after `arst_n` is released.
- R8: A cause that arrives while reset is still being stretched restarts the full period. Release then follows TRP_CYC edges after the new cause's last edge.
- R9: `rst_active_o` equals `rst_o` in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous power-on initialisation, active low |
| supply_ok_i | input | 1 | Supply above threshold, synchronous |
| mr_n_i | input | 1 | Manual reset request, active low |
| wdt_expire_i | input | 1 | Watchdog expiry pulse, one cycle |
| rst_n_o | output | 1 | Reset, active low |
| rst_o | output | 1 | Reset, active high |
| rst_active_o | output | 1 | Reset-active state, used to hold the watchdog |

## Verification
The bench builds the block with TRP_CYC = 40 and GLITCH_CYC = 20. With these values the exact release edge can be counted for every cause in a few dozen cycles. The glitch window boundary is also reachable: the bench applies pulses one cycle short of the window and pulses exactly as long as it. A random phase of several thousand cycles then overlaps causes, so stretch restarts and manual releases that land in the middle of a stretch occur many times.

// File: rtl/rst_sup_pkg.sv
package rst_sup_pkg;

  // Consecutive-low run length, saturating at limit-1.
  function automatic int unsigned low_run_next(input logic level_n,
                                               input int unsigned run,
                                               input int unsigned limit);
    if (level_n) return 0;
    if (run >= limit - 1) return limit - 1;
    return run + 1;
  endfunction

  // Stretch counter: reload on cause, else count down to zero.
  function automatic int unsigned stretch_next(input logic cause,
                                               input int unsigned cnt,
                                               input int unsigned period);
    if (cause) return period;
    if (cnt != 0) return cnt - 1;
    return 0;
  endfunction

  // Reset stays active while a cause is present or more than one count remains.
  function automatic logic stretch_active(input logic cause,
                                          input int unsigned cnt);
    return cause || (cnt > 1);
  endfunction

endpackage

// File: rtl/rst_mr_filter.sv
module rst_mr_filter #(
  parameter int unsigned GLITCH_CYC = 20
) (
  input  logic clk,
  input  logic arst_n,
  input  logic mr_n_i,
  output logic mr_low_o
);
  import rst_sup_pkg::*;

  localparam int unsigned CW = $clog2(GLITCH_CYC + 1);

  logic [CW-1:0] run_q;
  logic          low_q;
  logic          reach;

  assign reach = (32'(run_q) == GLITCH_CYC - 1);

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      run_q <= '0;
      low_q <= 1'b0;
    end else begin
      run_q <= CW'(low_run_next(mr_n_i, 32'(run_q), GLITCH_CYC));
      if (mr_n_i)     low_q <= 1'b0;
      else if (reach) low_q <= 1'b1;
    end
  end

  assign mr_low_o = low_q;
endmodule

// File: rtl/rst_stretch.sv
module rst_stretch #(
  parameter int unsigned TRP_CYC = 30000
) (
  input  logic clk,
  input  logic arst_n,
  input  logic cause_i,
  output logic active_o,
  output logic active_n_o
);
  import rst_sup_pkg::*;

  localparam int unsigned CW = $clog2(TRP_CYC + 1);
  localparam logic [CW-1:0] FULL = CW'(TRP_CYC);

  logic [CW-1:0] cnt_q;
  logic          act_q;
  logic          act_n_q;
  logic          act_d;

  assign act_d = stretch_active(cause_i, 32'(cnt_q));

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      cnt_q   <= FULL;
      act_q   <= 1'b1;
      act_n_q <= 1'b0;
    end else begin
      cnt_q   <= CW'(stretch_next(cause_i, 32'(cnt_q), TRP_CYC));
      act_q   <= act_d;
      act_n_q <= ~act_d;
    end
  end

  assign active_o   = act_q;
  assign active_n_o = act_n_q;
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int unsigned TRP_CYC    = 30000,
  parameter int unsigned GLITCH_CYC = 20
) (
  input  logic clk,
  input  logic arst_n,
  input  logic supply_ok_i,
  input  logic mr_n_i,
  input  logic wdt_expire_i,
  output logic rst_n_o,
  output logic rst_o,
  output logic rst_active_o
);
  logic mr_low;
  logic cause_now;
  logic act;
  logic act_n;

  rst_mr_filter #(.GLITCH_CYC(GLITCH_CYC)) u_filt (
    .clk      (clk),
    .arst_n   (arst_n),
    .mr_n_i   (mr_n_i),
    .mr_low_o (mr_low)
  );

  assign cause_now = !supply_ok_i || mr_low || wdt_expire_i;

  rst_stretch #(.TRP_CYC(TRP_CYC)) u_str (
    .clk        (clk),
    .arst_n     (arst_n),
    .cause_i    (cause_now),
    .active_o   (act),
    .active_n_o (act_n)
  );

  assign rst_o        = act;
  assign rst_n_o      = act_n;
  assign rst_active_o = act;
endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk #(
  parameter int unsigned TRP_CYC = 30000
) (
  input logic clk,
  input logic arst_n,
  input logic cause_now,
  input logic mr_low,
  input logic mr_n_i,
  input logic wdt_expire_i,
  input logic supply_ok_i,
  input logic rst_o,
  input logic rst_n_o
);
  int unsigned quiet_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)        quiet_q <= 0;
    else if (cause_now) quiet_q <= 0;
    else if (quiet_q < TRP_CYC + 2) quiet_q <= quiet_q + 1;
  end

  assert_supply_low_R1: assert property (@(posedge clk) disable iff (!arst_n)
    !supply_ok_i |=> rst_o);

  assert_release_window_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(rst_o) |-> quiet_q == TRP_CYC);

  assert_high_clears_filter_R3: assert property (@(posedge clk) disable iff (!arst_n)
    mr_n_i |=> !mr_low);

  assert_wdt_asserts_R5: assert property (@(posedge clk) disable iff (!arst_n)
    wdt_expire_i |=> rst_o);

  assert_complement_R6: assert property (@(posedge clk) disable iff (!arst_n)
    rst_n_o == !rst_o);

  assert_hold_in_window_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (quiet_q < TRP_CYC) |-> rst_o);
endmodule

bind rst_supervisor rst_supervisor_chk #(.TRP_CYC(TRP_CYC)) chk_i (
  .clk          (clk),
  .arst_n       (arst_n),
  .cause_now    (cause_now),
  .mr_low       (mr_low),
  .mr_n_i       (mr_n_i),
  .wdt_expire_i (wdt_expire_i),
  .supply_ok_i  (supply_ok_i),
  .rst_o        (rst_o),
  .rst_n_o      (rst_n_o)
);

// File: tb/rst_supervisor_tb_top.sv
`timescale 1ns/1ps
module rst_supervisor_tb_top;
  localparam int TRP = 40;
  localparam int GL  = 20;

  logic clk = 1'b0;
  logic arst_n = 1'b0;
  logic sup = 1'b1;
  logic mr_n = 1'b1;
  logic wdt = 1'b0;
  logic rst_n, rst, ract;
  int   n_chk = 0;
  int   n_fail = 0;
  bit   done = 1'b0;

  always #2.5 clk = ~clk;

  rst_supervisor #(.TRP_CYC(TRP), .GLITCH_CYC(GL)) dut_i (
    .clk(clk), .arst_n(arst_n), .supply_ok_i(sup), .mr_n_i(mr_n),
    .wdt_expire_i(wdt), .rst_n_o(rst_n), .rst_o(rst), .rst_active_o(ract)
  );

  // Reference: consecutive low samples and edges since last cause.
  int m_low = 0;
  int m_since = 0;

  function automatic bit exp_cause(bit s, int low, bit w);
    return !s || (low >= GL) || w;
  endfunction

  function automatic bit exp_rst(int since);
    return since < TRP;
  endfunction

  always @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      m_low = 0;
      m_since = 0;
    end else begin
      if (exp_cause(sup, m_low, wdt)) m_since = 0;
      else if (m_since < TRP + 5)     m_since = m_since + 1;
      m_low = mr_n ? 0 : m_low + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the reference, away from the edge.
  always @(negedge clk) if (!done) begin
    chk(rst_n == !rst, "R6 complement", rst_n, !rst);
    chk(ract == rst, "R9 active status", ract, rst);
    if (arst_n) chk(rst == exp_rst(m_since), "R1/R8 model", rst, exp_rst(m_since));
  end

  task automatic count_edges(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (rst && n < TRP + 50);
  endtask

  task automatic idle(input int c);
    repeat (c) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired actual=1 expected=0");
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int n;
    process::self().srandom(32'h5eed_1234);
    idle(3);
    chk(rst === 1'b1 && rst_n === 1'b0, "R7 reset state", rst, 1);
    arst_n = 1'b1;
    count_edges(n);
    chk(n == TRP, "R7 power-on release edge", n, TRP);

    // R1 / R2: supply drop
    idle(5);
    sup = 1'b0;
    @(negedge clk);
    chk(rst == 1'b1, "R1 supply low asserts", rst, 1);
    idle(3);
    sup = 1'b1;
    count_edges(n);
    chk(n == TRP, "R2 supply release edge", n, TRP);

    // R5: watchdog pulse
    idle(5);
    wdt = 1'b1;
    @(negedge clk);
    wdt = 1'b0;
    chk(rst == 1'b1, "R5 watchdog asserts", rst, 1);
    count_edges(n);
    chk(n == TRP, "R5 watchdog pulse length", n, TRP);

    // R4: glitch one sample short of the window
    idle(5);
    mr_n = 1'b0;
    idle(GL - 1);
    mr_n = 1'b1;
    chk(rst == 1'b0, "R4 short low ignored during", rst, 0);
    idle(3);
    chk(rst == 1'b0, "R4 short low ignored after", rst, 0);

    // R3: low exactly the window length
    idle(5);
    mr_n = 1'b0;
    idle(GL);
    mr_n = 1'b1;
    count_edges(n);
    chk(n == TRP + 1, "R3 window-length low release edge", n, TRP + 1);

    // R3: long manual hold
    idle(5);
    mr_n = 1'b0;
    idle(GL + 30);
    chk(rst == 1'b1, "R3 manual held asserts", rst, 1);
    mr_n = 1'b1;
    count_edges(n);
    chk(n == TRP + 1, "R3 manual release edge", n, TRP + 1);

    // R8: retrigger during stretch
    idle(5);
    wdt = 1'b1; @(negedge clk); wdt = 1'b0;
    idle(TRP / 2);
    chk(rst == 1'b1, "R8 still stretching", rst, 1);
    wdt = 1'b1; @(negedge clk); wdt = 1'b0;
    count_edges(n);
    chk(n == TRP, "R8 restart full period", n, TRP);

    // Random phase with overlapping causes; reference compares every cycle.
    idle(5);
    for (int i = 0; i < 6000; i++) begin
      int r;
      r = $urandom_range(0, 999);
      if (r < 4)        sup = 1'b0;
      else if (r < 60)  sup = 1'b1;
      r = $urandom_range(0, 999);
      if (r < 15)       mr_n = ~mr_n;
      else if (r < 25)  mr_n = 1'b1;
      wdt = ($urandom_range(0, 499) == 0);
      @(negedge clk);
    end
    sup = 1'b1; mr_n = 1'b1; wdt = 1'b0;
    idle(TRP + GL + 5);
    chk(rst == 1'b0, "R2 quiet after random phase", rst, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule